// File: doc/BRIEF.md
# UART Interrupt Flag and Vector Controller

This block keeps the receive and transmit interrupt flags and their enables for one UART channel. It merges them into a single interrupt request and a prioritized vector code. The UART core reports events: the transmit buffer became ready, or a character was loaded into the receive buffer. A loaded character comes with error, break and address qualifiers. The bus side supplies strobes for transmit-buffer writes, receive-buffer reads and accesses to the vector register. Static control inputs select software reset, global interrupt enable, error and break interrupt enables, dormant mode and multiprocessor mode.

A loaded character sets the receive flag only if it passes the error, break and dormant rules. Software reads the vector to find the highest-priority pending and enabled source. That read, or a write to the same address, clears only that one flag in the same clock edge. Any other pending source then drives the request and vector from the next cycle.

Top module: `uart_irq_vec_ctrl`

## Requirements
- R1: After asynchronous reset, the transmit flag is 1 and the receive flag is 0. Both enables are 0, `brk_o` is 0, `irq_o` is 0 and `iv_o` is 0.
- R2: While `swrst_i` is 1, each clock edge puts flags, enables and break status into the R1 state. The next cycle shows `iv_o`=0, `irq_o`=0 and `brk_o`=0.
- R3: A `tx_rdy_i` pulse sets the transmit flag, and a `txbuf_wr_i` pulse clears it one edge later. If both occur in the same cycle, the set wins.
- R4: A qualified `rx_load_i` sets the receive flag, and `rxbuf_rd_i` clears it. If both occur in the same cycle, the set wins.
- R5: A loaded character with `rx_err_i`=1 sets the receive flag only when `err_ie_i`=1.
- R6: With `dormant_i`=1, a loaded character sets the receive flag only when `multiproc_i`=1 and `rx_addr_i`=1. With `multiproc_i`=0, no loaded character sets the flag.
- R7: With `brk_ie_i`=1, a loaded character with `rx_brk_i`=1 sets `brk_o` and the receive flag, whatever the error and dormant rules say. With `brk_ie_i`=0, a break character counts as an erroneous character and leaves `brk_o` alone. `brk_o` clears on `rxbuf_rd_i` or software reset, and a break set in the same cycle wins.
- R8: `irq_o` = `gie_i` AND (some flag is 1 with its enable 1).
- R9: `iv_o` is 0x0 when no enabled flag is pending, 0x2 for receive and 0x4 for transmit, and receive has priority. A disabled flag never affects `iv_o`.
- R10: `iv_acc_i` clears, at that clock edge, only the flag whose code `iv_o` shows in that cycle, so that value is the one the access returns. If the other flag is still pending, it shows from the next cycle. A set event in the same cycle wins over this clear.
- R11: `ie_we_i` loads the enables from `ie_wdata_i`, with bit 0 the receive enable and bit 1 the transmit enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swrst_i | input | 1 | Software reset, synchronous, level |
| gie_i | input | 1 | Global interrupt enable |
| err_ie_i | input | 1 | Erroneous characters may set receive flag |
| brk_ie_i | input | 1 | Break interrupt enable |
| dormant_i | input | 1 | Dormant mode |
| multiproc_i | input | 1 | Multiprocessor (address/data) mode |
| ie_we_i | input | 1 | Enable register write strobe |
| ie_wdata_i | input | 2 | Enable write data: bit0 receive, bit1 transmit |
| tx_rdy_i | input | 1 | Transmit buffer ready event |
| rx_load_i | input | 1 | Character loaded into receive buffer |
| rx_err_i | input | 1 | Loaded character has an error |
| rx_brk_i | input | 1 | Loaded character is a break |
| rx_addr_i | input | 1 | Loaded character is an address character |
| txbuf_wr_i | input | 1 | Transmit buffer write strobe |
| rxbuf_rd_i | input | 1 | Receive buffer read strobe |
| iv_acc_i | input | 1 | Vector register read or write strobe |
| irq_o | output | 1 | Interrupt request |
| iv_o | output | 4 | Interrupt vector code |
| brk_o | output | 1 | Break status |

## Verification
The hardest case to reach is a vector access while both flags are pending and enabled. It must clear receive only, and transmit must then appear at once. The same holds when a set event of the same flag lands in the access cycle. Directed sequences build both-pending states with each enable combination. A random phase then drives events, strobes and control bits with high density, so that accesses often meet simultaneous sets and clears. A bench reference model predicts the flags and outputs every cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned IV_W  = 4;
  localparam int unsigned N_SRC = 2;
  // index order is priority order
  localparam int unsigned SRC_RX = 0;
  localparam int unsigned SRC_TX = 1;
  localparam logic [N_SRC-1:0] FLAG_RST = 2'b10;

  localparam logic [IV_W-1:0] IV_NONE = 4'h0;
  localparam logic [IV_W-1:0] IV_RX   = 4'h2;
  localparam logic [IV_W-1:0] IV_TX   = 4'h4;

  function automatic logic [IV_W-1:0] src_code(input int unsigned idx);
    return IV_W'((idx + 1) * 2);
  endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic swrst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= RST_VAL;
    else if (swrst_i) q_o <= RST_VAL;
    else if (set_i)   q_o <= 1'b1;
    else if (clr_i)   q_o <= 1'b0;
  end
endmodule

// File: rtl/rx_char_qual.sv
module rx_char_qual (
  input  logic load_i,
  input  logic err_i,
  input  logic brk_i,
  input  logic addr_i,
  input  logic multiproc_i,
  input  logic dormant_i,
  input  logic err_ie_i,
  input  logic brk_ie_i,
  output logic flag_set_o,
  output logic brk_set_o
);
  logic brk_hit, bad_ok, dorm_ok;

  always_comb begin
    brk_hit    = load_i & brk_i & brk_ie_i;
    // without break enable a break is just an erroneous character
    bad_ok     = ~(err_i | brk_i) | err_ie_i;
    dorm_ok    = ~dormant_i | (multiproc_i & addr_i);
    brk_set_o  = brk_hit;
    flag_set_o = brk_hit | (load_i & bad_ok & dorm_ok);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = N_SRC
) (
  input  logic [N-1:0]    pend_i,
  output logic [N-1:0]    sel_o,
  output logic [IV_W-1:0] iv_o
);
  logic found;

  always_comb begin
    sel_o = '0;
    iv_o  = IV_NONE;
    found = 1'b0;
    for (int unsigned i = 0; i < N; i++) begin
      if (pend_i[i] && !found) begin
        found    = 1'b1;
        sel_o[i] = 1'b1;
        iv_o     = src_code(i);
      end
    end
  end
endmodule

// File: rtl/uart_irq_vec_ctrl.sv
module uart_irq_vec_ctrl
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            swrst_i,
  input  logic            gie_i,
  input  logic            err_ie_i,
  input  logic            brk_ie_i,
  input  logic            dormant_i,
  input  logic            multiproc_i,
  input  logic            ie_we_i,
  input  logic [1:0]      ie_wdata_i,
  input  logic            tx_rdy_i,
  input  logic            rx_load_i,
  input  logic            rx_err_i,
  input  logic            rx_brk_i,
  input  logic            rx_addr_i,
  input  logic            txbuf_wr_i,
  input  logic            rxbuf_rd_i,
  input  logic            iv_acc_i,
  output logic            irq_o,
  output logic [IV_W-1:0] iv_o,
  output logic            brk_o
);
  logic [N_SRC-1:0] flag_q, ie_q, set_ev, hw_clr, sel;
  logic             rx_set, brk_set;

  rx_char_qual u_qual (
    .load_i      (rx_load_i),
    .err_i       (rx_err_i),
    .brk_i       (rx_brk_i),
    .addr_i      (rx_addr_i),
    .multiproc_i (multiproc_i),
    .dormant_i   (dormant_i),
    .err_ie_i    (err_ie_i),
    .brk_ie_i    (brk_ie_i),
    .flag_set_o  (rx_set),
    .brk_set_o   (brk_set)
  );

  always_comb begin
    set_ev         = '0;
    hw_clr         = '0;
    set_ev[SRC_RX] = rx_set;
    set_ev[SRC_TX] = tx_rdy_i;
    hw_clr[SRC_RX] = rxbuf_rd_i;
    hw_clr[SRC_TX] = txbuf_wr_i;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    irq_flag_cell #(.RST_VAL(FLAG_RST[g])) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .swrst_i (swrst_i),
      .set_i   (set_ev[g]),
      .clr_i   (hw_clr[g] | (iv_acc_i & sel[g])),
      .q_o     (flag_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ie_q <= '0;
    else if (swrst_i) ie_q <= '0;
    else if (ie_we_i) ie_q <= ie_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         brk_o <= 1'b0;
    else if (swrst_i)    brk_o <= 1'b0;
    else if (brk_set)    brk_o <= 1'b1;
    else if (rxbuf_rd_i) brk_o <= 1'b0;
  end

  irq_prio_enc #(.N(N_SRC)) u_enc (
    .pend_i (flag_q & ie_q),
    .sel_o  (sel),
    .iv_o   (iv_o)
  );

  assign irq_o = gie_i & |(flag_q & ie_q);
endmodule

// File: rtl/uart_irq_vec_chk.sv
module uart_irq_vec_chk
  import uart_irq_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            swrst_i,
  input logic            gie_i,
  input logic            brk_ie_i,
  input logic            tx_rdy_i,
  input logic            rx_load_i,
  input logic            rx_brk_i,
  input logic            txbuf_wr_i,
  input logic            iv_acc_i,
  input logic            irq_o,
  input logic [IV_W-1:0] iv_o,
  input logic            brk_o
);
  // R2
  swrst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_i |=> (iv_o == IV_NONE) && !irq_o && !brk_o);

  // R3
  tx_wr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txbuf_wr_i && !tx_rdy_i && !swrst_i) |=> (iv_o != IV_TX));

  // R7
  brk_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_load_i && rx_brk_i && brk_ie_i && !swrst_i) |=> brk_o);

  // R9
  iv_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iv_o == IV_NONE) || (iv_o == IV_RX) || (iv_o == IV_TX));

  // R10
  acc_clears_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iv_acc_i && iv_o == IV_RX && !rx_load_i && !swrst_i) |=> (iv_o != IV_RX));

  // R8
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_i && (iv_o != IV_NONE));
endmodule

bind uart_irq_vec_ctrl uart_irq_vec_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .swrst_i    (swrst_i),
  .gie_i      (gie_i),
  .brk_ie_i   (brk_ie_i),
  .tx_rdy_i   (tx_rdy_i),
  .rx_load_i  (rx_load_i),
  .rx_brk_i   (rx_brk_i),
  .txbuf_wr_i (txbuf_wr_i),
  .iv_acc_i   (iv_acc_i),
  .irq_o      (irq_o),
  .iv_o       (iv_o),
  .brk_o      (brk_o)
);

// File: tb/uart_irq_vec_ctrl_tb.sv
module uart_irq_vec_ctrl_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic swrst_i, gie_i, err_ie_i, brk_ie_i, dormant_i, multiproc_i, ie_we_i;
  logic [1:0] ie_wdata_i;
  logic tx_rdy_i, rx_load_i, rx_err_i, rx_brk_i, rx_addr_i;
  logic txbuf_wr_i, rxbuf_rd_i, iv_acc_i;
  logic irq_o, brk_o;
  logic [3:0] iv_o;

  int n_chk = 0, n_bad = 0;
  logic m_tx, m_rx, m_brk;
  logic [1:0] m_ie;

  always #4 clk_i = ~clk_i;

  uart_irq_vec_ctrl u_dut (.*);

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [3:0] exp_iv();
    if (m_rx && m_ie[0]) return 4'h2;
    if (m_tx && m_ie[1]) return 4'h4;
    return 4'h0;
  endfunction

  function automatic logic exp_irq();
    return gie_i && ((m_rx && m_ie[0]) || (m_tx && m_ie[1]));
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (iv_o !== exp_iv() || irq_o !== exp_irq() || brk_o !== m_brk) begin
      n_bad++;
      $display("FAIL %s: iv=%h irq=%b brk=%b expected iv=%h irq=%b brk=%b",
               tag, iv_o, irq_o, brk_o, exp_iv(), exp_irq(), m_brk);
    end
  endtask

  task automatic idle();
    swrst_i = 0; ie_we_i = 0; ie_wdata_i = 0; tx_rdy_i = 0; rx_load_i = 0;
    rx_err_i = 0; rx_brk_i = 0; rx_addr_i = 0; txbuf_wr_i = 0;
    rxbuf_rd_i = 0; iv_acc_i = 0;
  endtask

  // model of next state from the inputs now applied
  task automatic model();
    logic [3:0] iv_now;
    logic rset, bset, ok_bad, ok_dorm;
    iv_now  = exp_iv();
    bset    = rx_load_i && rx_brk_i && brk_ie_i;
    ok_bad  = !(rx_err_i || rx_brk_i) || err_ie_i;
    ok_dorm = !dormant_i || (multiproc_i && rx_addr_i);
    rset    = bset || (rx_load_i && ok_bad && ok_dorm);
    if (swrst_i) begin
      m_tx = 1; m_rx = 0; m_ie = 0; m_brk = 0;
    end else begin
      if (tx_rdy_i) m_tx = 1;
      else if (txbuf_wr_i || (iv_acc_i && iv_now == 4'h4)) m_tx = 0;
      if (rset) m_rx = 1;
      else if (rxbuf_rd_i || (iv_acc_i && iv_now == 4'h2)) m_rx = 0;
      if (bset) m_brk = 1;
      else if (rxbuf_rd_i) m_brk = 0;
      if (ie_we_i) m_ie = ie_wdata_i;
    end
  endtask

  // applied inputs take one edge; check on the following negedge
  task automatic step(input string tag);
    model();
    @(negedge clk_i);
    check(tag);
    idle();
  endtask

  task automatic set_ie(input logic [1:0] v, input string tag);
    ie_we_i = 1; ie_wdata_i = v; step(tag);
  endtask

  initial begin
    idle();
    gie_i = 1; err_ie_i = 0; brk_ie_i = 0; dormant_i = 0; multiproc_i = 0;
    m_tx = 1; m_rx = 0; m_ie = 0; m_brk = 0;
    repeat (3) @(negedge clk_i);
    check("R1 in reset");
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 after reset");
    set_ie(2'b10, "R1 R11 tx flag set at reset");
    set_ie(2'b11, "R11 both enables");
    // R3
    txbuf_wr_i = 1; step("R3 write clears tx");
    tx_rdy_i = 1; step("R3 ready sets tx");
    tx_rdy_i = 1; txbuf_wr_i = 1; step("R3 set wins");
    // R4 R9: rx over tx
    rx_load_i = 1; step("R4 R9 rx priority");
    rxbuf_rd_i = 1; step("R4 read clears rx");
    rx_load_i = 1; rxbuf_rd_i = 1; step("R4 set wins");
    // R10: both pending, access clears rx only, tx appears
    iv_acc_i = 1; step("R10 access clears rx");
    iv_acc_i = 1; step("R10 access clears tx");
    iv_acc_i = 1; step("R10 access with nothing pending");
    // R10 set during access wins
    rx_load_i = 1; step("R4 load");
    rx_load_i = 1; iv_acc_i = 1; step("R10 set beats clear");
    rxbuf_rd_i = 1; step("R4 clear");
    // R9 disabled flag ignored
    tx_rdy_i = 1; rx_load_i = 1; step("R9 both set");
    set_ie(2'b10, "R9 rx disabled shows tx");
    iv_acc_i = 1; step("R10 clears shown tx only");
    set_ie(2'b01, "R9 R10 rx still pending");
    gie_i = 0; step("R8 gie low");
    gie_i = 1; step("R8 gie high");
    rxbuf_rd_i = 1; step("R4 clear");
    // R5
    rx_load_i = 1; rx_err_i = 1; step("R5 error char blocked");
    err_ie_i = 1; rx_load_i = 1; rx_err_i = 1; step("R5 error char allowed");
    err_ie_i = 0; rxbuf_rd_i = 1; step("R5 clear");
    // R6
    dormant_i = 1;
    rx_load_i = 1; rx_addr_i = 1; step("R6 plain mode dormant blocks");
    multiproc_i = 1; rx_load_i = 1; step("R6 data char blocked");
    rx_load_i = 1; rx_addr_i = 1; step("R6 address char sets");
    rxbuf_rd_i = 1; step("R6 clear");
    // R7
    rx_load_i = 1; rx_brk_i = 1; step("R7 break without enable");
    brk_ie_i = 1; rx_load_i = 1; rx_brk_i = 1; step("R7 break sets in dormant");
    rxbuf_rd_i = 1; step("R7 read clears break");
    rx_load_i = 1; rx_brk_i = 1; rxbuf_rd_i = 1; step("R7 break set wins");
    // R2
    swrst_i = 1; step("R2 swrst");
    swrst_i = 1; tx_rdy_i = 1; rx_load_i = 1; ie_we_i = 1; ie_wdata_i = 3;
    step("R2 swrst held");
    set_ie(2'b10, "R2 tx flag after swrst");
    dormant_i = 0; multiproc_i = 0; brk_ie_i = 0;
    // random phase
    for (int i = 0; i < 20000; i++) begin
      swrst_i     = ($urandom % 64) == 0;
      gie_i       = ($urandom % 4) != 0;
      err_ie_i    = $urandom % 2;
      brk_ie_i    = $urandom % 2;
      dormant_i   = ($urandom % 4) == 0;
      multiproc_i = $urandom % 2;
      ie_we_i     = ($urandom % 8) == 0;
      ie_wdata_i  = 2'($urandom);
      tx_rdy_i    = ($urandom % 4) == 0;
      rx_load_i   = ($urandom % 3) == 0;
      rx_err_i    = ($urandom % 4) == 0;
      rx_brk_i    = ($urandom % 6) == 0;
      rx_addr_i   = $urandom % 2;
      txbuf_wr_i  = ($urandom % 4) == 0;
      rxbuf_rd_i  = ($urandom % 5) == 0;
      iv_acc_i    = ($urandom % 3) == 0;
      step("R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
  end
endmodule